// File: doc/BRIEF.md
# Data Lane High-Speed Burst Sequencer

This block drives the line-state sequence of one serial display data lane around a single high-speed burst. A request pulse, taken while the lane rests in LP-11 stop, walks the lane through its low-power entry states and an LP-00 prepare window. An HS-0 zero window follows, then a fixed sync byte. Payload bytes then come from a valid/ready byte stream. A trail window drives the complement of the last transmitted bit, and the lane returns to stop. A separate ultra-low-power path parks the lane and, on release, holds Mark-1 for a programmable wake-up count before the lane comes back to stop.

Every duration comes from a configuration input. The input is captured when the sequence starts. Values outside their legal range are clamped, and the clamp raises a sticky error flag. The block runs on the byte clock. The escape clock reaches it as two single-cycle enables: one per escape period and one per half escape period. Line drivers, serialisation and clock crossing sit outside the block.

Top module: `hs_lane_sequencer`

## Requirements
- R1: After reset, line_state is LP-11 (code 0), and hs_en, in_ready, burst_done and cfg_err are all low.
- R2: A burst_req seen in idle is followed by LP-11 for cfg_tlpx escape ticks, then LP-01 (code 1) for cfg_tlpx escape ticks, then LP-00 (code 2). A value of 0 is treated as 1.
- R3: LP-00 lasts cfg_prep half-escape ticks, with the value clamped to the range 2 to 5.
- R4: HS-0 (code 3) lasts cfg_zero byte-clock cycles, with the value clamped to 6 to 37. During HS-0, hs_en is 1 and hs_byte is 0.
- R5: The first cycle in HS data (code 4), directly after HS-0, carries hs_byte 8'hB8.
- R6: in_ready is high on the sync cycle and on each later data cycle until a byte with in_last has been taken. A byte accepted on one edge (in_valid and in_ready both high) appears on hs_byte in the next cycle, in order.
- R7: A cycle with in_ready high and in_valid low ends the payload. The next cycle is trail, or LP-11 when the trail count is 0.
- R8: Trail (code 5) lasts exactly cfg_trail cycles (0 to 15) with no added time. hs_en is 1, and every bit of hs_byte equals the complement of bit 7 of the last HS data byte, since bits leave LSB first.
- R9: After the trail the lane shows LP-11 with burst_done high for exactly one cycle. After that it is idle and accepts a new request.
- R10: cfg_err goes high when a burst starts with an out-of-range cfg_tlpx, cfg_prep or cfg_zero, or when ultra-low-power entry happens with cfg_wakeup equal to 0. Only reset clears it.
- R11: Configuration inputs changed after a request is accepted have no effect on that burst.
- R12: With ulps_req high and burst_req low in idle, the lane shows ULPS (code 7) for as long as ulps_req stays high. On release it shows Mark-1 (code 6) for cfg_wakeup escape ticks (0 is treated as 1) and then LP-11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| esc_tick | input | 1 | One-cycle enable per escape-clock period |
| esc_half_tick | input | 1 | One-cycle enable per half escape-clock period |
| burst_req | input | 1 | Start a burst (sampled in idle) |
| ulps_req | input | 1 | Enter and hold ultra-low-power state |
| cfg_tlpx | input | 8 | Low-power state length in escape ticks |
| cfg_prep | input | 3 | Prepare length in half-escape ticks |
| cfg_zero | input | 6 | HS-0 length in byte cycles |
| cfg_trail | input | 4 | Trail length in byte cycles |
| cfg_wakeup | input | 32 | Mark-1 length in escape ticks |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Payload byte is the last of the burst |
| in_ready | output | 1 | Payload byte accepted this cycle when valid |
| line_state | output | 3 | Lane state code |
| hs_en | output | 1 | High-speed drivers active |
| hs_byte | output | 8 | High-speed byte, LSB sent first |
| burst_done | output | 1 | One-cycle end-of-burst pulse |
| cfg_err | output | 1 | Sticky clamped-configuration flag |

## Verification
A wrong sequencer state appears on line_state in the very next cycle, because the code is decoded straight from the state register. A duration counter that is off by one shows as a window one enable too long or too short, and the bench counts enables inside each window to catch this. A lost or extra payload register stage appears on the first data byte after the sync byte. A wrong trail level shows during the trail window. A clamp or snapshot fault shows only as a wrong window length in a later burst, so the sweeps revisit every field after the configuration has been changed.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hB8;

    localparam int PREP_MIN = 2;
    localparam int PREP_MAX = 5;
    localparam int ZERO_MIN = 6;
    localparam int ZERO_MAX = 37;

    typedef enum logic [2:0] {
        LS_LP11     = 3'd0,
        LS_LP01     = 3'd1,
        LS_LP00     = 3'd2,
        LS_HS_ZERO  = 3'd3,
        LS_HS_DATA  = 3'd4,
        LS_HS_TRAIL = 3'd5,
        LS_MARK1    = 3'd6,
        LS_ULPS     = 3'd7
    } line_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_REQ11, ST_LP01, ST_PREP, ST_ZERO, ST_SYNC,
        ST_DATA, ST_TRAIL, ST_END, ST_ULPS, ST_WAKE
    } seq_e;

    typedef struct packed {
        line_e             line;
        logic              hs_en;
        logic [BYTE_W-1:0] hs_byte;
    } lane_out_s;

    function automatic logic [31:0] clamp32(input logic [31:0] v,
                                            input logic [31:0] lo,
                                            input logic [31:0] hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/hsl_timer.sv
module hsl_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             en,
    input  logic [CNT_W-1:0] target,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (en)        cnt <= cnt + 1'b1;
    end

    assign hit = en && (cnt == target - 1'b1);
endmodule

// File: rtl/hsl_cfg_latch.sv
module hsl_cfg_latch
    import hsl_pkg::*;
#(
    parameter int TLPX_W  = 8,
    parameter int PREP_W  = 3,
    parameter int ZERO_W  = 6,
    parameter int TRAIL_W = 4,
    parameter int WAKE_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_burst,
    input  logic               load_wake,
    input  logic [TLPX_W-1:0]  raw_tlpx,
    input  logic [PREP_W-1:0]  raw_prep,
    input  logic [ZERO_W-1:0]  raw_zero,
    input  logic [TRAIL_W-1:0] raw_trail,
    input  logic [WAKE_W-1:0]  raw_wake,
    output logic [TLPX_W-1:0]  tlpx_q,
    output logic [PREP_W-1:0]  prep_q,
    output logic [ZERO_W-1:0]  zero_q,
    output logic [TRAIL_W-1:0] trail_q,
    output logic [WAKE_W-1:0]  wake_q,
    output logic               cfg_err
);
    logic [TLPX_W-1:0] tlpx_c;
    logic [PREP_W-1:0] prep_c;
    logic [ZERO_W-1:0] zero_c;
    logic [WAKE_W-1:0] wake_c;
    logic              burst_bad, wake_bad;

    always_comb begin
        tlpx_c    = (raw_tlpx == '0) ? TLPX_W'(1) : raw_tlpx;
        prep_c    = PREP_W'(clamp32(32'(raw_prep), PREP_MIN, PREP_MAX));
        zero_c    = ZERO_W'(clamp32(32'(raw_zero), ZERO_MIN, ZERO_MAX));
        wake_c    = (raw_wake == '0) ? WAKE_W'(1) : raw_wake;
        burst_bad = (tlpx_c != raw_tlpx) || (prep_c != raw_prep) || (zero_c != raw_zero);
        wake_bad  = (wake_c != raw_wake);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tlpx_q  <= TLPX_W'(1);
            prep_q  <= PREP_W'(PREP_MIN);
            zero_q  <= ZERO_W'(ZERO_MIN);
            trail_q <= '0;
            wake_q  <= WAKE_W'(1);
            cfg_err <= 1'b0;
        end else begin
            if (load_burst) begin
                tlpx_q  <= tlpx_c;
                prep_q  <= prep_c;
                zero_q  <= zero_c;
                trail_q <= raw_trail;
            end
            if (load_wake) wake_q <= wake_c;
            if ((load_burst && burst_bad) || (load_wake && wake_bad)) cfg_err <= 1'b1;
        end
    end

    // R10
    cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);
endmodule

// File: rtl/hs_lane_sequencer.sv
module hs_lane_sequencer
    import hsl_pkg::*;
#(
    parameter int TLPX_W  = 8,
    parameter int PREP_W  = 3,
    parameter int ZERO_W  = 6,
    parameter int TRAIL_W = 4,
    parameter int WAKE_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               esc_tick,
    input  logic               esc_half_tick,
    input  logic               burst_req,
    input  logic               ulps_req,
    input  logic [TLPX_W-1:0]  cfg_tlpx,
    input  logic [PREP_W-1:0]  cfg_prep,
    input  logic [ZERO_W-1:0]  cfg_zero,
    input  logic [TRAIL_W-1:0] cfg_trail,
    input  logic [WAKE_W-1:0]  cfg_wakeup,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    input  logic               in_last,
    output logic               in_ready,
    output logic [2:0]         line_state,
    output logic               hs_en,
    output logic [7:0]         hs_byte,
    output logic               burst_done,
    output logic               cfg_err
);
    localparam int MSB = BYTE_W - 1;

    seq_e              state, state_n;
    logic [TLPX_W-1:0] tlpx_q;
    logic [PREP_W-1:0] prep_q;
    logic [ZERO_W-1:0] zero_q;
    logic [TRAIL_W-1:0] trail_q;
    logic [WAKE_W-1:0] wake_q;
    logic              load_burst, load_wake;
    logic              t_en, t_hit;
    logic [WAKE_W-1:0] t_tgt;
    logic [BYTE_W-1:0] data_q;
    logic              last_q, trail_lvl, accept;
    seq_e              after_payload;
    lane_out_s         lo;

    hsl_cfg_latch #(
        .TLPX_W(TLPX_W), .PREP_W(PREP_W), .ZERO_W(ZERO_W),
        .TRAIL_W(TRAIL_W), .WAKE_W(WAKE_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .load_burst(load_burst), .load_wake(load_wake),
        .raw_tlpx(cfg_tlpx), .raw_prep(cfg_prep), .raw_zero(cfg_zero),
        .raw_trail(cfg_trail), .raw_wake(cfg_wakeup),
        .tlpx_q(tlpx_q), .prep_q(prep_q), .zero_q(zero_q),
        .trail_q(trail_q), .wake_q(wake_q), .cfg_err(cfg_err)
    );

    hsl_timer #(.CNT_W(WAKE_W)) u_timer (
        .clk(clk), .rst(rst), .restart(state_n != state),
        .en(t_en), .target(t_tgt), .hit(t_hit)
    );

    assign in_ready      = (state == ST_SYNC) || (state == ST_DATA && !last_q);
    assign accept        = in_ready && in_valid;
    assign after_payload = (trail_q == '0) ? ST_END : ST_TRAIL;

    always_comb begin
        state_n    = state;
        load_burst = 1'b0;
        load_wake  = 1'b0;
        t_en       = 1'b0;
        t_tgt      = '0;
        case (state)
            ST_IDLE: begin
                if (burst_req) begin
                    state_n = ST_REQ11; load_burst = 1'b1;
                end else if (ulps_req) begin
                    state_n = ST_ULPS;  load_wake  = 1'b1;
                end
            end
            ST_REQ11: begin
                t_en = esc_tick; t_tgt = WAKE_W'(tlpx_q);
                if (t_hit) state_n = ST_LP01;
            end
            ST_LP01: begin
                t_en = esc_tick; t_tgt = WAKE_W'(tlpx_q);
                if (t_hit) state_n = ST_PREP;
            end
            ST_PREP: begin
                t_en = esc_half_tick; t_tgt = WAKE_W'(prep_q);
                if (t_hit) state_n = ST_ZERO;
            end
            ST_ZERO: begin
                t_en = 1'b1; t_tgt = WAKE_W'(zero_q);
                if (t_hit) state_n = ST_SYNC;
            end
            ST_SYNC:  state_n = accept ? ST_DATA : after_payload;
            ST_DATA:  state_n = accept ? ST_DATA : after_payload;
            ST_TRAIL: begin
                t_en = 1'b1; t_tgt = WAKE_W'(trail_q);
                if (t_hit) state_n = ST_END;
            end
            ST_END:   state_n = ST_IDLE;
            ST_ULPS:  if (!ulps_req) state_n = ST_WAKE;
            ST_WAKE: begin
                t_en = esc_tick; t_tgt = wake_q;
                if (t_hit) state_n = ST_IDLE;
            end
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            data_q    <= '0;
            last_q    <= 1'b0;
            trail_lvl <= 1'b0;
        end else begin
            state <= state_n;
            if (state == ST_ZERO) last_q <= 1'b0;
            if (accept) begin
                data_q <= in_data;
                last_q <= in_last;
            end
            if (state == ST_SYNC) trail_lvl <= ~SYNC_BYTE[MSB];
            if (state == ST_DATA) trail_lvl <= ~data_q[MSB];
        end
    end

    always_comb begin
        lo = '{line: LS_LP11, hs_en: 1'b0, hs_byte: '0};
        case (state)
            ST_LP01:  lo.line = LS_LP01;
            ST_PREP:  lo.line = LS_LP00;
            ST_ZERO:  begin lo.line = LS_HS_ZERO; lo.hs_en = 1'b1; end
            ST_SYNC:  begin lo.line = LS_HS_DATA; lo.hs_en = 1'b1; lo.hs_byte = SYNC_BYTE; end
            ST_DATA:  begin lo.line = LS_HS_DATA; lo.hs_en = 1'b1; lo.hs_byte = data_q; end
            ST_TRAIL: begin lo.line = LS_HS_TRAIL; lo.hs_en = 1'b1; lo.hs_byte = {BYTE_W{trail_lvl}}; end
            ST_ULPS:  lo.line = LS_ULPS;
            ST_WAKE:  lo.line = LS_MARK1;
            default:  lo.line = LS_LP11;
        endcase
    end

    assign line_state = lo.line;
    assign hs_en      = lo.hs_en;
    assign hs_byte    = lo.hs_byte;
    assign burst_done = (state == ST_END);

    // R2
    lp01_order_chk: assert property (@(posedge clk) disable iff (rst)
        line_state == LS_LP01 |=> (line_state == LS_LP01 || line_state == LS_LP00));
    // R3
    prep_exit_chk: assert property (@(posedge clk) disable iff (rst)
        line_state == LS_LP00 |=> (line_state == LS_LP00 || line_state == LS_HS_ZERO));
    // R5
    sync_after_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (line_state == LS_HS_DATA && $past(line_state) == LS_HS_ZERO) |-> hs_byte == SYNC_BYTE);
    // R7
    starve_end_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (line_state == LS_HS_TRAIL || line_state == LS_LP11));
    // R8
    trail_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (line_state == LS_HS_TRAIL && $past(line_state) == LS_HS_TRAIL) |-> $stable(hs_byte));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        burst_done |=> !burst_done);
endmodule

// File: tb/hs_lane_sequencer_tb.sv
module hs_lane_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        esc_tick = 1'b0, esc_half_tick = 1'b0;
    logic        burst_req = 1'b0, ulps_req = 1'b0;
    logic [7:0]  cfg_tlpx = 8'd1;
    logic [2:0]  cfg_prep = 3'd2;
    logic [5:0]  cfg_zero = 6'd6;
    logic [3:0]  cfg_trail = 4'd0;
    logic [31:0] cfg_wakeup = 32'd1;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        in_ready, hs_en, burst_done, cfg_err;
    logic [2:0]  line_state;
    logic [7:0]  hs_byte;

    int nchk = 0, nfail = 0, cyc = 0;
    bit finished = 0, exp_err = 0;
    logic [2:0] s_line;
    logic [7:0] s_byte;
    logic s_en, s_rdy, s_done, s_err;

    always #4 clk = ~clk;

    hs_lane_sequencer u_dut (
        .clk(clk), .rst(rst), .esc_tick(esc_tick), .esc_half_tick(esc_half_tick),
        .burst_req(burst_req), .ulps_req(ulps_req),
        .cfg_tlpx(cfg_tlpx), .cfg_prep(cfg_prep), .cfg_zero(cfg_zero),
        .cfg_trail(cfg_trail), .cfg_wakeup(cfg_wakeup),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .line_state(line_state), .hs_en(hs_en), .hs_byte(hs_byte),
        .burst_done(burst_done), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        s_line = line_state; s_byte = hs_byte; s_en = hs_en;
        s_rdy = in_ready; s_done = burst_done; s_err = cfg_err;
        esc_tick      = (cyc % 4 == 0);
        esc_half_tick = (cyc % 2 == 0);
    endtask

    function automatic logic [7:0] pay(input int seed, input int i);
        return 8'(seed * 29 + i * 71 + 13);
    endfunction

    task automatic run_burst(input int tl, input int pr, input int ze, input int tr,
                             input int nb, input int stv, input int seed, input bit chg);
        int tle, pre, zee, nsend, acc, hsd, seg_c, seg_e, seg_h, nseg, guard;
        int bad_byte, bad_rdy, bad_zero, bad_trail, bad_order;
        int exp_seq[7];
        logic [2:0] cur;
        logic [7:0] lastb;
        logic tlvl;
        tle   = (tl == 0) ? 1 : tl;
        pre   = (pr < 2) ? 2 : ((pr > 5) ? 5 : pr);
        zee   = (ze < 6) ? 6 : ((ze > 37) ? 37 : ze);
        nsend = (stv < nb) ? stv : nb;
        if (tl == 0 || pr < 2 || pr > 5 || ze < 6 || ze > 37) exp_err = 1;
        lastb = (nsend == 0) ? 8'hB8 : pay(seed, nsend - 1);
        tlvl  = ~lastb[7];
        exp_seq = '{0, 1, 2, 3, 4, 5, 0};
        if (tr == 0) exp_seq[5] = 0;
        cfg_tlpx = 8'(tl); cfg_prep = 3'(pr); cfg_zero = 6'(ze); cfg_trail = 4'(tr);
        acc = 0; hsd = 0; nseg = 0; guard = 0;
        bad_byte = 0; bad_rdy = 0; bad_zero = 0; bad_trail = 0; bad_order = 0;
        step(); burst_req = 1'b1;
        step(); burst_req = 1'b0;
        if (chg) begin cfg_tlpx = 8'd9; cfg_prep = 3'd4; cfg_zero = 6'd30; cfg_trail = 4'd12; end
        cur = s_line; seg_c = 0; seg_e = 0; seg_h = 0;
        forever begin
            if (s_line != cur) begin
                if (cur != 3'(exp_seq[nseg])) bad_order++;
                case (cur)
                    3'd0: chk(seg_e == tle, "R2 LP-11 escape ticks", seg_e, tle);
                    3'd1: chk(seg_e == tle, "R2 LP-01 escape ticks", seg_e, tle);
                    3'd2: chk(seg_h == pre, "R3 LP-00 half ticks", seg_h, pre);
                    3'd3: chk(seg_c == zee, "R4 HS-0 cycles", seg_c, zee);
                    3'd4: chk(seg_c == nsend + 1, "R6 R7 HS data cycles", seg_c, nsend + 1);
                    3'd5: chk(seg_c == tr, "R8 trail cycles", seg_c, tr);
                    default: bad_order++;
                endcase
                nseg++;
                cur = s_line; seg_c = 0; seg_e = 0; seg_h = 0;
                if (cur == 3'd0) break;
            end
            seg_c++; seg_e += int'(esc_tick); seg_h += int'(esc_half_tick);
            if (s_rdy != (s_line == 3'd4 && hsd != nb)) bad_rdy++;
            if (s_line == 3'd3 && (s_byte != 8'd0 || !s_en)) bad_zero++;
            if (s_line == 3'd5 && (s_byte != {8{tlvl}} || !s_en)) bad_trail++;
            if (s_line == 3'd4) begin
                if (s_byte != ((hsd == 0) ? 8'hB8 : pay(seed, hsd - 1))) bad_byte++;
                hsd++;
            end
            in_valid = (acc < nsend);
            in_data  = pay(seed, acc);
            in_last  = (acc == nb - 1);
            if (s_rdy && in_valid) acc++;
            guard++;
            if (guard > 3000) break;
            step();
        end
        in_valid = 1'b0; in_last = 1'b0;
        chk(bad_order == 0 && nseg == ((tr == 0) ? 5 : 6), "R2 state order", nseg, (tr == 0) ? 5 : 6);
        chk(bad_zero == 0, "R4 HS-0 byte and enable", bad_zero, 0);
        chk(bad_byte == 0, "R5 R6 sync and payload bytes", bad_byte, 0);
        chk(bad_rdy == 0, "R6 in_ready pattern", bad_rdy, 0);
        chk(acc == nsend, "R6 R7 accepted bytes", acc, nsend);
        chk(bad_trail == 0, "R8 trail level", bad_trail, 0);
        chk(s_done == 1'b1 && s_line == 3'd0, "R9 done on return to LP-11", int'(s_done), 1);
        step();
        chk(s_done == 1'b0 && s_line == 3'd0, "R9 done lasts one cycle", int'(s_done), 0);
        chk(s_err == exp_err, "R10 cfg_err", int'(s_err), int'(exp_err));
    endtask

    task automatic run_ulps(input int wk, input int hold);
        int e, wke, bad, guard;
        wke = (wk == 0) ? 1 : wk;
        if (wk == 0) exp_err = 1;
        cfg_wakeup = 32'(wk);
        bad = 0; e = 0; guard = 0;
        step(); ulps_req = 1'b1;
        step();
        chk(s_line == 3'd7, "R12 ULPS entry", int'(s_line), 7);
        repeat (hold) begin step(); if (s_line != 3'd7) bad++; end
        chk(bad == 0, "R12 ULPS held", bad, 0);
        ulps_req = 1'b0;
        step();
        while (s_line == 3'd6 && guard < 1000) begin
            e += int'(esc_tick); guard++;
            step();
        end
        chk(e == wke, "R12 Mark-1 escape ticks", e, wke);
        chk(s_line == 3'd0, "R12 return to LP-11", int'(s_line), 0);
        chk(s_err == exp_err, "R10 cfg_err after wake", int'(s_err), int'(exp_err));
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        chk(s_line == 3'd0 && !s_en && !s_rdy && !s_done && !s_err, "R1 reset state",
            int'(s_line), 0);
        run_ulps(3, 4);
        run_burst(1, 2, 6, 3, 4, 99, 1, 0);
        for (int p = 2; p <= 5; p++) run_burst(1, p, 6, 1, 1, 99, p, 0);
        run_burst(2, 3, 7, 2, 2, 99, 5, 0);
        run_burst(3, 4, 20, 4, 3, 99, 6, 0);
        run_burst(1, 2, 36, 0, 1, 99, 7, 0);
        run_burst(1, 5, 37, 5, 2, 99, 8, 0);
        for (int t = 0; t <= 15; t++) run_burst(1, 2, 6, t, (t % 4) + 1, 99, 10 + t, 0);
        run_burst(1, 2, 6, 2, 3, 0, 30, 0);
        run_burst(1, 2, 6, 0, 3, 0, 31, 0);
        run_burst(1, 3, 8, 3, 5, 2, 32, 0);
        // R11: configuration changed right after the request is accepted
        run_burst(2, 3, 10, 4, 2, 99, 33, 1);
        run_burst(1, 2, 6, 2, 1, 99, 34, 1);
        chk(!s_err, "R10 no error while in range", int'(s_err), 0);
        run_burst(1, 0, 6, 1, 1, 99, 40, 0);
        run_burst(1, 1, 6, 1, 1, 99, 41, 0);
        run_burst(1, 6, 6, 1, 1, 99, 42, 0);
        run_burst(1, 7, 6, 1, 1, 99, 43, 0);
        run_burst(1, 2, 0, 1, 1, 99, 44, 0);
        run_burst(1, 2, 5, 1, 1, 99, 45, 0);
        run_burst(1, 2, 38, 1, 1, 99, 46, 0);
        run_burst(1, 2, 63, 1, 1, 99, 47, 0);
        run_burst(0, 2, 6, 1, 1, 99, 48, 0);
        run_burst(2, 2, 6, 1, 2, 99, 49, 0);
        rst = 1'b1; exp_err = 0;
        step(); step();
        rst = 1'b0;
        step();
        chk(!s_err && s_line == 3'd0, "R1 R10 reset clears cfg_err", int'(s_err), 0);
        run_ulps(0, 2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule